// File: doc/BRIEF.md
# Combinable Shift-Rotate Micro-Operation Unit

This unit executes one shift-rotate register word in a single clock. The word operates on one 16-bit accumulator and on the 1-bit extend flag E. The surrounding datapath supplies the current values of both accumulators and of E. It also supplies the decoded word, which holds a register select, a first shift code, a clear-E flag, a low-bit skip flag and a second shift code.

The unit applies the selected steps in a fixed order. When `valid_i` is high, it registers the new accumulator values, the new E and a skip indication, and presents them one clock later. The accumulator that was not selected passes through unchanged.

Rotates through E treat E and the accumulator as one 17-bit ring. The skip test sits between the two shift steps, so it sees the value after the first shift and before the second.

Top module: `srot_unit`

## Requirements
- R1: While `rst_ni` is low, `a_o`, `b_o`, `e_o` and `skip_o` are all zero.
- R2: When `valid_i` is high at a rising edge, the results appear on the outputs after that edge. When `valid_i` is low, `a_o`, `b_o` and `e_o` hold their values and `skip_o` is 0.
- R3: The steps of one word run in this order: first shift (`shift1_i`), then clear E, then the skip test, then second shift (`shift2_i`).
- R4: Code 1 is the sign-keeping left shift. Bits 14..0 move up one place, bit 0 becomes 0 and bit 15 keeps its value. E is unchanged.
- R5: Code 2 is the arithmetic right shift. Bits 15..1 move down one place, and bit 15 keeps its value, so bit 14 becomes the old sign. E is unchanged.
- R6: Codes 3 and 4 rotate the 16-bit accumulator one place left and one place right. Code 8 rotates it four places left. E is unchanged.
- R7: Code 5 shifts left one place, sets bit 0 to 0 and forces bit 15 to 0. E is unchanged.
- R8: Code 6 rotates {E, acc} one place left: E takes the old bit 15 and bit 0 takes the old E. Code 7 rotates one place right: E takes the old bit 0 and bit 15 takes the old E.
- R9: When `skip_lsb_i` is set, `skip_o` is 1 if bit 0 of the accumulator after the first shift is 0. When `skip_lsb_i` is clear, `skip_o` is 0.
- R10: `sel_b_i`=0 selects A and `sel_b_i`=1 selects B. The other accumulator output takes its input value unchanged.
- R11: Code 0 and codes 9 to 15 leave the accumulator and E unchanged.
- R12: `clr_e_i`=1 sets E to 0 after the first shift and before the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Execute the word this cycle |
| sel_b_i | input | 1 | 0 selects A, 1 selects B |
| shift1_i | input | 4 | First shift/rotate code |
| clr_e_i | input | 1 | Clear E between the shifts |
| skip_lsb_i | input | 1 | Enable the low-bit-zero skip test |
| shift2_i | input | 4 | Second shift/rotate code |
| a_i | input | 16 | Current A |
| b_i | input | 16 | Current B |
| e_i | input | 1 | Current E |
| a_o | output | 16 | Registered A result |
| b_o | output | 16 | Registered B result |
| e_o | output | 1 | Registered E result |
| skip_o | output | 1 | Registered skip indication |

## Verification
The assertions assume that the accumulator and E inputs are stable around the rising edge. They also assume that `valid_i` is driven to a known level in every cycle after reset, because the hold checks compare consecutive cycles.

The stimulus changes inputs only on falling edges. It draws all sixteen code values for both shift fields, so unused codes are exercised alongside the defined ones. It also inserts idle cycles with changed inputs to check that the outputs hold.

// File: rtl/srot_pkg.sv
package srot_pkg;
  localparam int unsigned CODE_W = 4;

  typedef enum logic [CODE_W-1:0] {
    SR_NONE = 4'd0,
    SR_ASL  = 4'd1,
    SR_ASR  = 4'd2,
    SR_ROL  = 4'd3,
    SR_ROR  = 4'd4,
    SR_LSLC = 4'd5,
    SR_EROL = 4'd6,
    SR_EROR = 4'd7,
    SR_ROL4 = 4'd8
  } sr_code_e;
endpackage

// File: rtl/srot_stage.sv
module srot_stage
  import srot_pkg::*;
#(
  parameter int unsigned W   = 16,
  parameter int unsigned NIB = 4
) (
  input  logic [CODE_W-1:0] code_i,
  input  logic [W-1:0]      acc_i,
  input  logic              ext_i,
  output logic [W-1:0]      acc_o,
  output logic              ext_o
);
  localparam int unsigned MSB = W - 1;

  always_comb begin
    acc_o = acc_i;
    ext_o = ext_i;
    case (code_i)
      SR_ASL:  acc_o = {acc_i[MSB], acc_i[MSB-2:0], 1'b0};
      SR_ASR:  acc_o = {acc_i[MSB], acc_i[MSB:1]};
      SR_ROL:  acc_o = {acc_i[MSB-1:0], acc_i[MSB]};
      SR_ROR:  acc_o = {acc_i[0], acc_i[MSB:1]};
      SR_LSLC: acc_o = {1'b0, acc_i[MSB-2:0], 1'b0};
      SR_EROL: {ext_o, acc_o} = {acc_i, ext_i};
      SR_EROR: {acc_o, ext_o} = {ext_i, acc_i};
      SR_ROL4: acc_o = {acc_i[MSB-NIB:0], acc_i[MSB:W-NIB]};
      default: ;
    endcase
  end
endmodule

// File: rtl/srot_route.sv
module srot_route #(
  parameter int unsigned W = 16
) (
  input  logic         sel_b_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] res_i,
  output logic [W-1:0] opnd_o,
  output logic [W-1:0] a_nxt_o,
  output logic [W-1:0] b_nxt_o
);
  assign opnd_o  = sel_b_i ? b_i : a_i;
  assign a_nxt_o = sel_b_i ? a_i : res_i;
  assign b_nxt_o = sel_b_i ? res_i : b_i;
endmodule

// File: rtl/srot_unit.sv
module srot_unit
  import srot_pkg::*;
#(
  parameter int unsigned W   = 16,
  parameter int unsigned NIB = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              sel_b_i,
  input  logic [CODE_W-1:0] shift1_i,
  input  logic              clr_e_i,
  input  logic              skip_lsb_i,
  input  logic [CODE_W-1:0] shift2_i,
  input  logic [W-1:0]      a_i,
  input  logic [W-1:0]      b_i,
  input  logic              e_i,
  output logic [W-1:0]      a_o,
  output logic [W-1:0]      b_o,
  output logic              e_o,
  output logic              skip_o
);
  logic [W-1:0] opnd, acc1, acc2, a_nxt, b_nxt;
  logic         e1, e1c, e2, skip_c;

  srot_route #(.W(W)) i_route (
    .sel_b_i(sel_b_i), .a_i(a_i), .b_i(b_i), .res_i(acc2),
    .opnd_o(opnd), .a_nxt_o(a_nxt), .b_nxt_o(b_nxt)
  );

  srot_stage #(.W(W), .NIB(NIB)) i_stage_first (
    .code_i(shift1_i), .acc_i(opnd), .ext_i(e_i), .acc_o(acc1), .ext_o(e1)
  );

  // clear E and the skip test sit between the two shift stages
  assign e1c    = clr_e_i ? 1'b0 : e1;
  assign skip_c = skip_lsb_i & ~acc1[0];

  srot_stage #(.W(W), .NIB(NIB)) i_stage_second (
    .code_i(shift2_i), .acc_i(acc1), .ext_i(e1c), .acc_o(acc2), .ext_o(e2)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_o    <= '0;
      b_o    <= '0;
      e_o    <= 1'b0;
      skip_o <= 1'b0;
    end else begin
      skip_o <= valid_i & skip_c;
      if (valid_i) begin
        a_o <= a_nxt;
        b_o <= b_nxt;
        e_o <= e2;
      end
    end
  end
endmodule

// File: rtl/srot_chk.sv
module srot_chk
  import srot_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic              sel_b_i,
  input logic [CODE_W-1:0] shift1_i,
  input logic              clr_e_i,
  input logic              skip_lsb_i,
  input logic [CODE_W-1:0] shift2_i,
  input logic [W-1:0]      a_i,
  input logic [W-1:0]      b_i,
  input logic              e_i,
  input logic [W-1:0]      a_o,
  input logic [W-1:0]      b_o,
  input logic              e_o,
  input logic              skip_o
);
  always_comb begin
    if (!rst_ni) a_r1_reset_clear: assert (a_o == '0 && b_o == '0 && !e_o && !skip_o);
  end

  a_r2_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(a_o) && $stable(b_o) && $stable(e_o) && !skip_o);

  a_r9_no_skip_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !skip_lsb_i |=> !skip_o);

  a_r10_keep_b: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !sel_b_i |=> b_o == $past(b_i));

  a_r10_keep_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && sel_b_i |=> a_o == $past(a_i));

  a_r12_clear_e: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && clr_e_i && shift2_i != SR_EROL && shift2_i != SR_EROR |=> !e_o);

  a_r4_sign_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !sel_b_i && shift1_i == SR_ASL && shift2_i == SR_NONE
    |=> a_o[W-1] == $past(a_i[W-1]));

  a_r11_ext_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !clr_e_i && shift1_i == SR_NONE && shift2_i == SR_NONE |=> e_o == $past(e_i));
endmodule

bind srot_unit srot_chk #(.W(W)) i_srot_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .sel_b_i(sel_b_i),
  .shift1_i(shift1_i), .clr_e_i(clr_e_i), .skip_lsb_i(skip_lsb_i), .shift2_i(shift2_i),
  .a_i(a_i), .b_i(b_i), .e_i(e_i), .a_o(a_o), .b_o(b_o), .e_o(e_o), .skip_o(skip_o)
);

// File: tb/test_srot_unit.sv
module test_srot_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0, sel_b_i = 1'b0, clr_e_i = 1'b0, skip_lsb_i = 1'b0;
  logic [3:0]  shift1_i = '0, shift2_i = '0;
  logic [15:0] a_i = '0, b_i = '0;
  logic        e_i = 1'b0;
  logic [15:0] a_o, b_o;
  logic        e_o, skip_o;

  int checks = 0;
  int errors = 0;

  always #5 clk_i = ~clk_i;

  srot_unit i_srot_unit (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .sel_b_i(sel_b_i),
    .shift1_i(shift1_i), .clr_e_i(clr_e_i), .skip_lsb_i(skip_lsb_i), .shift2_i(shift2_i),
    .a_i(a_i), .b_i(b_i), .e_i(e_i), .a_o(a_o), .b_o(b_o), .e_o(e_o), .skip_o(skip_o)
  );

  // reference: returns {e, acc} after one shift step
  function automatic logic [16:0] ref_step(input logic [3:0] c, input logic [15:0] v, input logic e);
    logic [15:0] r;
    logic        ne;
    r = v; ne = e;
    if (c == 4'd1) r = (v << 1) & 16'h7FFF | (v & 16'h8000);
    else if (c == 4'd2) r = (v >> 1) | (v & 16'h8000);
    else if (c == 4'd3) r = (v << 1) | (v >> 15);
    else if (c == 4'd4) r = (v >> 1) | (v << 15);
    else if (c == 4'd5) r = (v << 1) & 16'h7FFF;
    else if (c == 4'd6) begin r = (v << 1) | {15'd0, e}; ne = v[15]; end
    else if (c == 4'd7) begin r = (v >> 1) | {e, 15'd0}; ne = v[0]; end
    else if (c == 4'd8) r = (v << 4) | (v >> 12);
    return {ne, r};
  endfunction

  task automatic check(input string req, input logic [33:0] got, input logic [33:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got a=%h b=%h e=%b skip=%b, expected a=%h b=%h e=%b skip=%b",
               req, got[33:18], got[17:2], got[1], got[0], exp[33:18], exp[17:2], exp[1], exp[0]);
    end
  endtask

  task automatic run_op(input string req, input logic sel, input logic [3:0] c1, input logic clr,
                        input logic sk, input logic [3:0] c2,
                        input logic [15:0] a, input logic [15:0] b, input logic e);
    logic [16:0] s1, s2;
    logic [15:0] opnd, ea, eb;
    logic        ee, es;
    opnd = sel ? b : a;
    s1 = ref_step(c1, opnd, e);
    es = sk && !s1[0];
    if (clr) s1[16] = 1'b0;
    s2 = ref_step(c2, s1[15:0], s1[16]);
    ea = sel ? a : s2[15:0];
    eb = sel ? s2[15:0] : b;
    ee = s2[16];
    @(negedge clk_i);
    valid_i = 1'b1; sel_b_i = sel; shift1_i = c1; clr_e_i = clr; skip_lsb_i = sk;
    shift2_i = c2; a_i = a; b_i = b; e_i = e;
    @(negedge clk_i);
    valid_i = 1'b0;
    check(req, {a_o, b_o, e_o, skip_o}, {ea, eb, ee, es});
  endtask

  task automatic idle_check();
    logic [33:0] prev;
    prev = {a_o, b_o, e_o, 1'b0};
    valid_i = 1'b0; a_i = ~a_i; b_i = ~b_i; e_i = ~e_i; skip_lsb_i = 1'b1;
    shift1_i = 4'd3;
    @(negedge clk_i);
    check("R2 hold", {a_o, b_o, e_o, skip_o}, prev);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    a_i = 16'hFFFF; b_i = 16'hFFFF; e_i = 1'b1; valid_i = 1'b1; skip_lsb_i = 1'b1;
    repeat (3) @(negedge clk_i);
    check("R1 reset", {a_o, b_o, e_o, skip_o}, 34'd0);
    valid_i = 1'b0;
    rst_ni = 1'b1;

    // R4 sign-keeping left shift
    run_op("R4", 0, 4'd1, 0, 0, 4'd0, 16'h4001, 16'h1234, 1'b1);
    run_op("R4", 0, 4'd1, 0, 0, 4'd0, 16'hC000, 16'h1234, 1'b0);
    // R5 arithmetic right
    run_op("R5", 1, 4'd2, 0, 0, 4'd0, 16'h0000, 16'h8002, 1'b1);
    // R6 rotates
    run_op("R6", 0, 4'd3, 0, 0, 4'd0, 16'h8001, 16'h0, 1'b0);
    run_op("R6", 0, 4'd4, 0, 0, 4'd0, 16'h8001, 16'h0, 1'b0);
    run_op("R6", 1, 4'd8, 0, 0, 4'd0, 16'h0, 16'hA5C3, 1'b0);
    // R7 clear-sign left
    run_op("R7", 0, 4'd5, 0, 0, 4'd0, 16'hFFFF, 16'h0, 1'b1);
    // R8 rotates through E
    run_op("R8", 0, 4'd6, 0, 0, 4'd0, 16'h8000, 16'h0, 1'b0);
    run_op("R8", 0, 4'd7, 0, 0, 4'd0, 16'h0001, 16'h0, 1'b0);
    run_op("R8", 1, 4'd0, 0, 0, 4'd7, 16'h0, 16'h0000, 1'b1);
    // R3 ordering: rotate right through E, clear E, skip test, rotate left through E
    run_op("R3", 0, 4'd7, 1, 1, 4'd6, 16'h0001, 16'h0, 1'b0);
    // R9 skip sees value between stages
    run_op("R9", 0, 4'd4, 0, 1, 4'd0, 16'h0002, 16'h0, 1'b0);
    run_op("R9", 0, 4'd3, 0, 1, 4'd0, 16'h8000, 16'h0, 1'b0);
    run_op("R9", 1, 4'd0, 0, 0, 4'd0, 16'h0, 16'h0000, 1'b0);
    // R12 clear E alone
    run_op("R12", 1, 4'd0, 1, 0, 4'd0, 16'h0, 16'h5555, 1'b1);
    // R11 unused codes
    run_op("R11", 0, 4'd9, 0, 0, 4'd15, 16'h1357, 16'h2468, 1'b1);
    // R10 register selection
    run_op("R10", 1, 4'd3, 0, 0, 4'd3, 16'hDEAD, 16'h0101, 1'b0);
    idle_check();

    for (int i = 0; i < 3000; i++) begin
      run_op("R3 random", 1'($urandom), 4'($urandom), 1'($urandom), 1'($urandom), 4'($urandom),
             16'($urandom), 16'($urandom), 1'($urandom));
      if (i % 50 == 0) idle_check();
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule